// File: doc/BRIEF.md
# Twiddle-Grouped In-Place FFT Engine

This block computes a radix-2 decimation-in-frequency FFT of N complex fixed-point samples held in its own sample memory. Software or an upstream block writes the N samples through a load port while the engine is idle. It then pulses `start` and waits for the one-cycle `done` pulse. The results are read back through a registered read port. Results are left in bit-reversed order: the bin k value sits at the address whose AW-bit index is k with its bits mirrored.

The butterflies run in an order that fetches each non-unity twiddle factor from the twiddle table once per transform. A first phase walks super-stages. Each super-stage takes a group of twiddle exponents and applies each fetched factor across all the DIF stages that use it. A second phase then runs every butterfly whose twiddle is 1. Those butterflies bypass the complex multiply.

Every butterfly halves its outputs with rounding, so a full transform returns X[k]/N and never overflows. The engine uses one memory port: each butterfly takes four clocks (read upper, read lower, write upper, write lower), and each twiddle fetch adds one clock.

Top module: `fft_tg_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `rd_re`/`rd_im` read zero.
- R2: While idle, `ld_en` writes `ld_re`/`ld_im` to sample address `ld_addr`. Reading address a returns that sample on `rd_re`/`rd_im` one clock after `rd_addr` is presented.
- R3: After `done`, address bitrev(k) holds X[k]/N within ±2 LSB in both parts. Here X[k] = Σ x[n]·(cos θ − j·sin θ) with θ = 2πnk/N.
- R4: Each butterfly stores the sum (a+b) and the twiddled difference, each divided by two with round-half-up. A transform of N equal full-scale samples (all +32767 or all −32768 real) therefore gives exactly that value at address 0 and exactly zero everywhere else.
- R5: Each non-unity twiddle is fetched once. A transform therefore takes exactly (N/2−1) + 4·(N/2)·log2(N) clocks from the clock edge that accepts `start` to the edge that raises `done` (135 for N=16). Of those butterflies, N−1 use the unity twiddle.
- R6: `busy` is high from the edge after an accepted `start` until `done` rises. `done` is high for exactly one clock, and `busy` is low in that clock.
- R7: A `start` pulse while busy is ignored. The running transform keeps its timing, and no second `done` follows.
- R8: `ld_en` while busy is ignored. The transform result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one sample (idle only) |
| ld_addr | input | AW | Sample address for the write |
| ld_re | input | DW | Real part, signed |
| ld_im | input | DW | Imaginary part, signed |
| start | input | 1 | Begin a transform (idle only) |
| rd_addr | input | AW | Read-back address |
| rd_re | output | DW | Registered real part at `rd_addr` |
| rd_im | output | DW | Registered imaginary part at `rd_addr` |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A scheduler that skips, repeats or reorders a twiddle group shows up in two places. The latency from `start` to `done` moves off its fixed count in that same transform. The read-back bins also leave the ±2 LSB band around the reference DFT, because a butterfly run before its inputs are final spreads the error over several bins. A wrong rounding or twiddle sign shows up in the full-scale and single-tone patterns as soon as the first transform is read back. A control path that honours `start` or a load while busy either shifts `done` or corrupts the bins of that transform.

// File: rtl/fft_tg_pkg.sv
`timescale 1ns/1ps
package fft_tg_pkg;

   // engine sequencing: one state per clock of a butterfly, plus a twiddle fetch slot
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RDA,
      ST_RDB,
      ST_WRA,
      ST_WRB
   } eng_state_t;

endpackage

// File: rtl/fft_tg_rom.sv
`timescale 1ns/1ps
// Twiddle table: entry k holds cos(2*pi*k/N) and -sin(2*pi*k/N) in Q(FRAC) format.
module fft_tg_rom #(
   parameter int N    = 16,
   parameter int TW   = 16,
   parameter int FRAC = 14,
   parameter int IW   = 5
) (
   input  logic [IW-1:0]        idx,
   output logic signed [TW-1:0] w_re,
   output logic signed [TW-1:0] w_im
);
   localparam int  HALF  = N / 2;
   localparam real SCALE = real'(1 << FRAC);

   if (TW < FRAC + 2) begin : g_bad_width
      $error("fft_tg_rom: TW must hold FRAC fraction bits, a unit bit and a sign");
   end

   logic signed [TW-1:0] cos_t [HALF];
   logic signed [TW-1:0] nsin_t [HALF];

   for (genvar k = 0; k < HALF; k++) begin : g_entry
      localparam real ANG = 6.283185307179586 * k / N;
      localparam int  CV  = $rtoi($floor(SCALE * $cos(ANG) + 0.5));
      localparam int  SV  = $rtoi($floor(-SCALE * $sin(ANG) + 0.5));
      assign cos_t[k]  = TW'(CV);
      assign nsin_t[k] = TW'(SV);
   end

   always_comb begin
      w_re = '0;
      w_im = '0;
      for (int k = 0; k < HALF; k++) begin
         if (idx == IW'(k)) begin
            w_re = cos_t[k];
            w_im = nsin_t[k];
         end
      end
   end
endmodule

// File: rtl/fft_tg_bfly.sv
`timescale 1ns/1ps
// DIF butterfly with per-butterfly halving: upper = (a+b)/2, lower = (a-b)*w/2.
module fft_tg_bfly #(
   parameter int DW   = 16,
   parameter int TW   = 16,
   parameter int FRAC = 14
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   input  logic signed [TW-1:0] w_re,
   input  logic signed [TW-1:0] w_im,
   input  logic                 unity,
   output logic signed [DW-1:0] s_re,
   output logic signed [DW-1:0] s_im,
   output logic signed [DW-1:0] d_re,
   output logic signed [DW-1:0] d_im
);
   localparam int PW = DW + TW + 2;
   localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW-1)) - 1);
   localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
   localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< FRAC;

   function automatic logic signed [DW-1:0] clamp(input logic signed [PW-1:0] x);
      if (x > MAXV)      return MAXV[DW-1:0];
      else if (x < MINV) return MINV[DW-1:0];
      else               return x[DW-1:0];
   endfunction

   logic signed [PW-1:0] ar, ai, br, bi, dr, di, wr, wi;
   logic signed [PW-1:0] pr, pi, ur, ui;

   always_comb begin
      ar = PW'(a_re);  ai = PW'(a_im);
      br = PW'(b_re);  bi = PW'(b_im);
      wr = PW'(w_re);  wi = PW'(w_im);
      dr = ar - br;
      di = ai - bi;
      s_re = clamp((ar + br + PW'(1)) >>> 1);
      s_im = clamp((ai + bi + PW'(1)) >>> 1);
      // twiddled path: one rounding covers both the Q(FRAC) product and the halving
      pr = (dr * wr - di * wi + HALF_LSB) >>> (FRAC + 1);
      pi = (dr * wi + di * wr + HALF_LSB) >>> (FRAC + 1);
      // unity path: no multiply
      ur = (dr + PW'(1)) >>> 1;
      ui = (di + PW'(1)) >>> 1;
      d_re = unity ? clamp(ur) : clamp(pr);
      d_im = unity ? clamp(ui) : clamp(pi);
   end
endmodule

// File: rtl/fft_tg_sched.sv
`timescale 1ns/1ps
// Butterfly address scheduler: phase one walks super-stages grouped by twiddle,
// phase two walks the unity-twiddle butterflies stage by stage.
module fft_tg_sched #(
   parameter int N  = 16,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          step,
   output logic [AW-1:0] addr_a,
   output logic [AW-1:0] addr_b,
   output logic [AW:0]   tw_idx,
   output logic          unity,
   output logic          last,
   output logic          new_tw
);
   localparam int P = AW + 1;

   logic          phase2, nx_phase2;
   logic [AW-1:0] ss0, nx_ss0, st, nx_st;
   logic [P-1:0]  tw, nx_tw, i0, nx_i0;
   logic [P-1:0]  n3, n4, i0_adv, tw_adv;

   always_comb begin
      n3        = P'(N) >> st;
      n4        = n3 >> 1;
      i0_adv    = i0 + n3;
      tw_adv    = tw + (P'(2) << ss0);
      nx_phase2 = phase2;
      nx_ss0    = ss0;
      nx_st     = st;
      nx_tw     = tw;
      nx_i0     = i0;
      new_tw    = 1'b0;
      last      = 1'b0;
      if (i0_adv < P'(N)) begin
         nx_i0 = i0_adv;
      end else if (!phase2) begin
         if (st < ss0) begin
            nx_st = st + 1'b1;
            nx_i0 = tw >> (st + 1'b1);
         end else if (tw_adv < P'(N/2)) begin
            nx_tw  = tw_adv;
            nx_st  = '0;
            nx_i0  = tw_adv;
            new_tw = 1'b1;
         end else if (ss0 < AW'(AW-2)) begin
            nx_ss0 = ss0 + 1'b1;
            nx_tw  = P'(1) << (ss0 + 1'b1);
            nx_st  = '0;
            nx_i0  = P'(1) << (ss0 + 1'b1);
            new_tw = 1'b1;
         end else begin
            nx_phase2 = 1'b1;
            nx_st     = '0;
            nx_tw     = '0;
            nx_i0     = '0;
         end
      end else if (st < AW'(AW-1)) begin
         nx_st = st + 1'b1;
         nx_i0 = '0;
      end else begin
         last = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase2 <= 1'b0;
         ss0    <= '0;
         st     <= '0;
         tw     <= '0;
         i0     <= '0;
      end else if (init) begin
         phase2 <= 1'b0;
         ss0    <= '0;
         st     <= '0;
         tw     <= P'(1);
         i0     <= P'(1);
      end else if (step && !last) begin
         phase2 <= nx_phase2;
         ss0    <= nx_ss0;
         st     <= nx_st;
         tw     <= nx_tw;
         i0     <= nx_i0;
      end
   end

   assign addr_a = i0[AW-1:0];
   assign addr_b = AW'(i0 + n4);
   assign tw_idx = tw;
   assign unity  = phase2;

   AST_PAIR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ((i0 + n4) < P'(N)));  // R3
   AST_TW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !phase2) |-> (tw != '0));  // R5
endmodule

// File: rtl/fft_tg_engine.sv
`timescale 1ns/1ps
module fft_tg_engine #(
   parameter int N    = 16,
   parameter int DW   = 16,
   parameter int TW   = 16,
   parameter int FRAC = 14,
   parameter int AW   = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_en,
   input  logic [AW-1:0]        ld_addr,
   input  logic signed [DW-1:0] ld_re,
   input  logic signed [DW-1:0] ld_im,
   input  logic                 start,
   input  logic [AW-1:0]        rd_addr,
   output logic signed [DW-1:0] rd_re,
   output logic signed [DW-1:0] rd_im,
   output logic                 busy,
   output logic                 done
);
   import fft_tg_pkg::*;

   if (N < 4 || (1 << AW) != N) begin : g_bad_n
      $error("fft_tg_engine: N must be a power of two, at least 4");
   end

   eng_state_t state, nx_state;

   logic signed [DW-1:0] mem_re [N];
   logic signed [DW-1:0] mem_im [N];
   logic signed [DW-1:0] a_re, a_im, b_re, b_im;
   logic signed [DW-1:0] s_re, s_im, d_re, d_im;
   logic signed [TW-1:0] w_re, w_im, rom_re, rom_im;
   logic [AW-1:0]        addr_a, addr_b;
   logic [AW:0]          tw_idx;
   logic                 unity, last, new_tw, init, step;
   logic [AW:0]          fetch_cnt, unity_cnt;

   assign init = (state == ST_IDLE) && start;
   assign step = (state == ST_WRB);
   assign busy = (state != ST_IDLE);

   fft_tg_sched #(.N(N), .AW(AW)) u_sched (
      .clk(clk), .rst_n(rst_n), .init(init), .step(step),
      .addr_a(addr_a), .addr_b(addr_b), .tw_idx(tw_idx),
      .unity(unity), .last(last), .new_tw(new_tw)
   );

   fft_tg_rom #(.N(N), .TW(TW), .FRAC(FRAC), .IW(AW+1)) u_rom (
      .idx(tw_idx), .w_re(rom_re), .w_im(rom_im)
   );

   fft_tg_bfly #(.DW(DW), .TW(TW), .FRAC(FRAC)) u_bfly (
      .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .w_re(w_re), .w_im(w_im), .unity(unity),
      .s_re(s_re), .s_im(s_im), .d_re(d_re), .d_im(d_im)
   );

   always_comb begin
      nx_state = state;
      unique case (state)
         ST_IDLE:  if (start) nx_state = ST_FETCH;
         ST_FETCH: nx_state = ST_RDA;
         ST_RDA:   nx_state = ST_RDB;
         ST_RDB:   nx_state = ST_WRA;
         ST_WRA:   nx_state = ST_WRB;
         ST_WRB:   nx_state = last ? ST_IDLE : (new_tw ? ST_FETCH : ST_RDA);
         default:  nx_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         done      <= 1'b0;
         a_re      <= '0;  a_im <= '0;
         b_re      <= '0;  b_im <= '0;
         w_re      <= '0;  w_im <= '0;
         rd_re     <= '0;  rd_im <= '0;
         fetch_cnt <= '0;
         unity_cnt <= '0;
      end else begin
         state <= nx_state;
         done  <= step && last;
         rd_re <= mem_re[rd_addr];
         rd_im <= mem_im[rd_addr];
         if (init) begin
            fetch_cnt <= '0;
            unity_cnt <= '0;
         end
         if (state == ST_FETCH) begin
            w_re      <= rom_re;
            w_im      <= rom_im;
            fetch_cnt <= fetch_cnt + 1'b1;
         end
         if (state == ST_RDA) begin
            a_re <= mem_re[addr_a];
            a_im <= mem_im[addr_a];
         end
         if (state == ST_RDB) begin
            b_re <= mem_re[addr_b];
            b_im <= mem_im[addr_b];
         end
         if (step && unity) unity_cnt <= unity_cnt + 1'b1;
      end
   end

   // single write port: engine writes while busy, loads only while idle
   always_ff @(posedge clk) begin
      if (state == ST_WRA) begin
         mem_re[addr_a] <= s_re;
         mem_im[addr_a] <= s_im;
      end else if (state == ST_WRB) begin
         mem_re[addr_b] <= d_re;
         mem_im[addr_b] <= d_im;
      end else if (state == ST_IDLE && ld_en) begin
         mem_re[ld_addr] <= ld_re;
         mem_im[ld_addr] <= ld_im;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);  // R6
   AST_FETCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fetch_cnt == (AW+1)'(N/2 - 1)));  // R5
   AST_UNITY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (unity_cnt == (AW+1)'(N - 1)));  // R5
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> busy);  // R7
endmodule

// File: tb/tb_fft_tg_engine.sv
`timescale 1ns/1ps
module tb_fft_tg_engine;
   localparam int N    = 16;
   localparam int DW   = 16;
   localparam int AW   = 4;
   localparam int TOL  = 2;
   localparam int LAT  = (N/2 - 1) + 4 * (N/2) * AW;

   // each entry: kind[27:24], amplitude[23:8], bin or position[7:0]
   // kind 0 impulse, 1 constant, 2 complex tone, 3 real cosine, 4 ramp
   localparam logic [27:0] CASES [8] = '{
      {4'd0, 16'd8000,  8'd0},
      {4'd0, 16'd8000,  8'd5},
      {4'd1, 16'd5000,  8'd0},
      {4'd2, 16'd10000, 8'd1},
      {4'd2, 16'd9000,  8'd7},
      {4'd3, 16'd12000, 8'd3},
      {4'd4, 16'd20000, 8'd0},
      {4'd2, 16'd6000,  8'd12}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 ld_en = 1'b0;
   logic [AW-1:0]        ld_addr = '0;
   logic signed [DW-1:0] ld_re = '0;
   logic signed [DW-1:0] ld_im = '0;
   logic                 start = 1'b0;
   logic [AW-1:0]        rd_addr = '0;
   logic signed [DW-1:0] rd_re, rd_im;
   logic                 busy, done;

   int errors = 0;
   int checks = 0;
   int xr [N];
   int xi [N];

   always #2 clk = ~clk;

   fft_tg_engine #(.N(N), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
      .ld_re(ld_re), .ld_im(ld_im), .start(start), .rd_addr(rd_addr),
      .rd_re(rd_re), .rd_im(rd_im), .busy(busy), .done(done)
   );

   task automatic check(input string req, input string what, input int act, input int exp, input int tol);
      checks++;
      if (act > exp + tol || act < exp - tol) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int bitrev(input int k);
      int r = 0;
      for (int b = 0; b < AW; b++) if (k[b]) r |= 1 << (AW - 1 - b);
      return r;
   endfunction

   function automatic int rnd(input real v);
      return $rtoi($floor(v + 0.5));
   endfunction

   task automatic gen(input logic [27:0] c);
      int  kind = int'(c[27:24]);
      int  amp  = int'(c[23:8]);
      int  bin  = int'(c[7:0]);
      for (int n = 0; n < N; n++) begin
         real ang = 6.283185307179586 * bin * n / N;
         case (kind)
            0: begin xr[n] = (n == bin) ? amp : 0; xi[n] = (n == bin) ? -amp / 3 : 0; end
            1: begin xr[n] = amp; xi[n] = -amp / 2; end
            2: begin xr[n] = rnd(amp * $cos(ang)); xi[n] = rnd(amp * $sin(ang)); end
            3: begin xr[n] = rnd(amp * $cos(ang)); xi[n] = 0; end
            default: begin xr[n] = amp * n / N - amp / 2; xi[n] = (n % 3) * 1000; end
         endcase
      end
   endtask

   task automatic load_all();
      for (int n = 0; n < N; n++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = AW'(n); ld_re = DW'(xr[n]); ld_im = DW'(xi[n]);
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic read_word(input int a, output int re, output int im);
      @(negedge clk);
      rd_addr = AW'(a);
      @(posedge clk);
      @(negedge clk);
      re = int'(rd_re);
      im = int'(rd_im);
   endtask

   // inject: 1 = start pulse while busy, 2 = load while busy
   task automatic run(input int inject, output int cycles);
      int cnt = 0;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      while (cnt < 2000) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (cnt == 20) check("R6", "busy mid-transform", int'(busy), 1, 0);
         if (cnt == 40 && inject == 1) start = 1'b1;
         if (cnt == 40 && inject == 2) begin
            ld_en = 1'b1; ld_addr = AW'(3); ld_re = 16'sd12345; ld_im = -16'sd4321;
         end
         if (cnt == 41) begin start = 1'b0; ld_en = 1'b0; end
         if (done) break;
      end
      cycles = cnt;
      check("R6", "busy low while done", int'(busy), 0, 0);
      @(negedge clk);
      check("R6", "done width one cycle", int'(done), 0, 0);
   endtask

   task automatic compare_bins(input string req);
      for (int k = 0; k < N; k++) begin
         real sr = 0.0;
         real si = 0.0;
         int  ar, ai;
         for (int n = 0; n < N; n++) begin
            real th = 6.283185307179586 * n * k / N;
            sr += xr[n] * $cos(th) + xi[n] * $sin(th);
            si += xi[n] * $cos(th) - xr[n] * $sin(th);
         end
         read_word(bitrev(k), ar, ai);
         check(req, $sformatf("bin %0d real", k), ar, rnd(sr / N), TOL);
         check(req, $sformatf("bin %0d imag", k), ai, rnd(si / N), TOL);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog: actual no completion, expected done within %0d cycles", LAT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cyc, re, im;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy after reset", int'(busy), 0, 0);
      check("R1", "done after reset", int'(done), 0, 0);
      check("R1", "rd_re after reset", int'(rd_re), 0, 0);
      rst_n = 1'b1;

      // main table walk: R2 read-back, R3 transform, R5 latency
      for (int c = 0; c < 8; c++) begin
         gen(CASES[c]);
         load_all();
         if (c == 0) begin
            for (int n = 0; n < N; n++) begin
               read_word(n, re, im);
               check("R2", $sformatf("readback %0d real", n), re, xr[n], 0);
               check("R2", $sformatf("readback %0d imag", n), im, xi[n], 0);
            end
         end
         run(0, cyc);
         check("R5", "start-to-done clocks", cyc, LAT, 0);
         compare_bins("R3");
      end

      // R4: full-scale constant inputs, exact results
      for (int s = 0; s < 2; s++) begin
         int v = (s == 0) ? 32767 : -32768;
         for (int n = 0; n < N; n++) begin xr[n] = v; xi[n] = 0; end
         load_all();
         run(0, cyc);
         for (int a = 0; a < N; a++) begin
            read_word(a, re, im);
            check("R4", $sformatf("full scale %0d addr %0d real", v, a), re, (a == 0) ? v : 0, 0);
            check("R4", $sformatf("full scale %0d addr %0d imag", v, a), im, 0, 0);
         end
      end

      // R7: start while busy is ignored
      gen(CASES[3]);
      load_all();
      run(1, cyc);
      check("R7", "latency with start while busy", cyc, LAT, 0);
      begin
         int extra = 0;
         for (int t = 0; t < 30; t++) begin
            @(negedge clk);
            if (done || busy) extra++;
         end
         check("R7", "activity after done", extra, 0, 0);
      end
      compare_bins("R7");

      // R8: load while busy is ignored
      gen(CASES[5]);
      load_all();
      run(2, cyc);
      check("R8", "latency with load while busy", cyc, LAT, 0);
      compare_bins("R8");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule